// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serializer

This block turns a parallel word into a serial bit stream. Eight storage stages sit in a chain. Stage 0 takes the serial input, and the last stage drives the serial output and its inverse. The block runs on one free-running system clock. The external shift clock, the clock-inhibit line, the active-low load line, the serial input and the parallel word are treated as asynchronous. Each of them passes through a two-flop synchroniser before any logic uses it.

The two clock inputs are ORed into one effective clock, so they behave symmetrically. Holding either input high stops shifting. Holding either input low lets the other one clock the chain. A rising edge of the effective clock moves every stage one place toward the output. Driving the load line low copies the parallel word into the chain for as long as the line stays low. The load overrides any clock activity. The cycle in which the load line returns high never shifts.

Raising the inhibit input while the clock input is low is an illegal use, because it creates a spurious edge. The block reports this on a one-cycle violation output. A view of all stages is brought out for checking.

Top module: `gclk_piso`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0. This drives `q_o` to 0 and `q_n_o` to 1.
- R2: While `load_n_i` is low, stage i holds `par_i[i]`. Stage i is bit i of `stages_o`, and the last stage (bit WIDTH-1) drives `q_o`. This holds whatever the serial input does.
- R3: While `load_n_i` is low, toggling the clock inputs does not disturb the loaded word.
- R4: With `load_n_i` high and `clk_b_i` low, a rising edge on `clk_a_i` gives one shift. After it, stage 0 holds `ser_i` and each stage i>0 holds the previous value of stage i-1.
- R5: With `load_n_i` high, either clock input held high blocks all shifting. Every stage keeps its value while the other input toggles.
- R6: The clock inputs are symmetric. With `clk_a_i` low, a rising edge on `clk_b_i` gives one shift, as in R4.
- R7: A clock edge that reaches the block in the same synchronised cycle as the return of `load_n_i` to high does not shift. The loaded word stays.
- R8: `q_n_o` is always the inverse of `q_o`.
- R9: `inh_viol_o` pulses for one cycle when `clk_b_i` rises while `clk_a_i` is low. It stays low when `clk_b_i` rises while `clk_a_i` is high.
- R10: After a load, WIDTH shifts with `ser_i` held constant replace every stage with that constant. After WIDTH-1 shifts, the original stage 0 value sits in the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_a_i | input | 1 | Shift clock input (asynchronous) |
| clk_b_i | input | 1 | Clock-inhibit input, symmetric with `clk_a_i` (asynchronous) |
| load_n_i | input | 1 | Active-low parallel load, level sensitive (asynchronous) |
| ser_i | input | 1 | Serial data entering stage 0 |
| par_i | input | WIDTH | Parallel word; bit i goes to stage i |
| q_o | output | 1 | Last stage |
| q_n_o | output | 1 | Inverse of the last stage |
| stages_o | output | WIDTH | All stages; bit i is stage i |
| inh_viol_o | output | 1 | One-cycle pulse on an illegal raise of the inhibit |

## Verification
The assertions assume that each asynchronous input changes at most once per synchroniser settling time. An edge, a load and a serial level are then each seen as one clean level change in the synchronised domain. The stimulus holds every input level for four system cycles before it changes the next one. Serial and parallel data are set up before the clock edge that uses them. The inhibit is raised while the clock input is high, except in the one step that drives the second input as a clock on purpose to exercise the violation flag.

// File: rtl/gclk_piso_pkg.sv
// Shared definitions for the gated-clock serializer.
// Assumes: nothing beyond IEEE 1800-2017.
package gclk_piso_pkg;

    // Action the storage chain takes in one system cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } chain_act_e;

    // Bit positions inside the synchronised control bundle.
    localparam int unsigned CTL_CK  = 0;
    localparam int unsigned CTL_INH = 1;
    localparam int unsigned CTL_LDN = 2;
    localparam int unsigned CTL_SER = 3;
    localparam int unsigned CTL_W   = 4;

endpackage

// File: rtl/gclk_piso_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous inputs.
// Assumes: each input holds a level long enough to pass through STAGES flops;
// RST_VAL gives the quiet level of each bit so reset release creates no edge.
module gclk_piso_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         sys_clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // First flop captures the raw asynchronous level.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= async_i;
    end

    // Remaining flops settle metastability one stage at a time.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge sys_clk) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gclk_piso_edge.sv
// Combines the two synchronised clock inputs into one effective clock and
// finds its rising edges. Also flags an inhibit raise while the clock is low.
// Assumes: both inputs are already synchronised to sys_clk.
module gclk_piso_edge (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic ck_s,
    input  logic inh_s,
    output logic shift_pulse,
    output logic inh_viol
);

    logic comb_now;
    logic comb_q;
    logic inh_q;

    // Effective clock: either input high holds it high.
    assign comb_now = ck_s | inh_s;

    // Remember last-cycle levels; reset high so release makes no edge.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            comb_q <= 1'b1;
            inh_q  <= 1'b1;
        end else begin
            comb_q <= comb_now;
            inh_q  <= inh_s;
        end
    end

    // Rising edge of the effective clock requests one shift.
    assign shift_pulse = comb_now & ~comb_q;

    // Inhibit rose while the clock input was low: illegal, creates an edge.
    assign inh_viol = inh_s & ~inh_q & ~ck_s;

    AST_HELD_INHIBIT_BLOCKS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (inh_s && inh_q) |-> !shift_pulse); // R5

    AST_HELD_CLOCK_BLOCKS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (ck_s && $past(ck_s)) |-> !shift_pulse); // R5

    AST_VIOL_IMPLIES_SHIFT: assert property (@(posedge sys_clk) disable iff (!rst_n)
        inh_viol |-> shift_pulse); // R9

endmodule

// File: rtl/gclk_piso_core.sv
// Storage chain with level-driven parallel load, shift and hold.
// Assumes: load, serial and parallel inputs are synchronised; shift_pulse is
// a one-cycle request. Load wins over shifting; the cycle in which load ends
// never shifts.
module gclk_piso_core
    import gclk_piso_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             ld_s_n,
    input  logic             ser_s,
    input  logic [WIDTH-1:0] par_s,
    input  logic             shift_pulse,
    output logic [WIDTH-1:0] stages
);

    chain_act_e       act;
    logic             ld_q_n;
    logic [WIDTH-1:0] stages_q;

    // Pick this cycle's action: load, then end-of-load guard, then shift.
    always_comb begin
        if (!ld_s_n)          act = ACT_LOAD;
        else if (!ld_q_n)     act = ACT_HOLD;
        else if (shift_pulse) act = ACT_SHIFT;
        else                  act = ACT_HOLD;
    end

    // Track the load level of the last cycle to spot its release.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) ld_q_n <= 1'b1;
        else        ld_q_n <= ld_s_n;
    end

    // Update the chain according to the chosen action.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else begin
            case (act)
                ACT_LOAD:  stages_q <= par_s;
                ACT_SHIFT: stages_q <= {stages_q[WIDTH-2:0], ser_s};
                default:   stages_q <= stages_q;
            endcase
        end
    end

    assign stages = stages_q;

    AST_LOAD_TRACKS_WORD: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !ld_s_n |=> (stages_q == $past(par_s))); // R2

    AST_SHIFT_ONE_PLACE: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (shift_pulse && ld_s_n && ld_q_n) |=>
            (stages_q[0] == $past(ser_s)) &&
            (stages_q[WIDTH-1:1] == $past(stages_q[WIDTH-2:0]))); // R4

    AST_RELEASE_CYCLE_HOLDS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (ld_s_n && !ld_q_n) |=> $stable(stages_q)); // R7

    AST_QUIET_HOLDS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (ld_s_n && !shift_pulse) |=> $stable(stages_q)); // R5

endmodule

// File: rtl/gclk_piso.sv
// Top of the gated-clock parallel-load serializer.
// Assumes: all data and control inputs are asynchronous to sys_clk and
// change slowly relative to it. Quiet levels at reset: both clock inputs
// high, load inactive.
module gclk_piso
    import gclk_piso_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             clk_a_i,
    input  logic             clk_b_i,
    input  logic             load_n_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             q_o,
    output logic             q_n_o,
    output logic [WIDTH-1:0] stages_o,
    output logic             inh_viol_o
);

    localparam logic [CTL_W-1:0] CTL_RST = (CTL_W'(1) << CTL_CK)
                                         | (CTL_W'(1) << CTL_INH)
                                         | (CTL_W'(1) << CTL_LDN);

    logic [CTL_W-1:0] ctl_raw;
    logic [CTL_W-1:0] ctl_s;
    logic [WIDTH-1:0] par_s;
    logic             shift_pulse;
    logic             inh_viol;
    logic [WIDTH-1:0] stages;

    // Gather control inputs into one bundle for synchronising.
    always_comb begin
        ctl_raw          = '0;
        ctl_raw[CTL_CK]  = clk_a_i;
        ctl_raw[CTL_INH] = clk_b_i;
        ctl_raw[CTL_LDN] = load_n_i;
        ctl_raw[CTL_SER] = ser_i;
    end

    gclk_piso_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_RST)
    ) u_sync_ctl (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_s)
    );

    gclk_piso_sync #(
        .W       (WIDTH),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync_par (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .async_i (par_i),
        .sync_o  (par_s)
    );

    gclk_piso_edge u_edge (
        .sys_clk     (sys_clk),
        .rst_n       (rst_n),
        .ck_s        (ctl_s[CTL_CK]),
        .inh_s       (ctl_s[CTL_INH]),
        .shift_pulse (shift_pulse),
        .inh_viol    (inh_viol)
    );

    gclk_piso_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .sys_clk     (sys_clk),
        .rst_n       (rst_n),
        .ld_s_n      (ctl_s[CTL_LDN]),
        .ser_s       (ctl_s[CTL_SER]),
        .par_s       (par_s),
        .shift_pulse (shift_pulse),
        .stages      (stages)
    );

    assign stages_o   = stages;
    assign q_o        = stages[WIDTH-1];
    assign q_n_o      = ~stages[WIDTH-1];
    assign inh_viol_o = inh_viol;

    AST_RESET_CLEARS_LAST: assert property (@(posedge sys_clk)
        !rst_n |=> (q_o == 1'b0)); // R1

endmodule

// File: tb/gclk_piso_tb_top.sv
`timescale 1ns/1ps
module gclk_piso_tb_top;

    localparam int W = 8;

    // Step encoding: {op[2:0], ser, par[7:0]}
    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_SHA   = 3'd1;
    localparam logic [2:0] OP_SHB   = 3'd2;
    localparam logic [2:0] OP_INA   = 3'd3;
    localparam logic [2:0] OP_INB   = 3'd4;
    localparam logic [2:0] OP_LDCLK = 3'd5;
    localparam logic [2:0] OP_LDRET = 3'd6;

    localparam int NSTEP = 14;
    localparam logic [11:0] STEPS [NSTEP] = '{
        {OP_LOAD,  1'b0, 8'hA5},
        {OP_SHA,   1'b1, 8'h00},
        {OP_SHA,   1'b0, 8'hFF},
        {OP_SHB,   1'b1, 8'h00},
        {OP_INA,   1'b1, 8'h00},
        {OP_INB,   1'b0, 8'h00},
        {OP_LDCLK, 1'b1, 8'h3C},
        {OP_LDRET, 1'b0, 8'h96},
        {OP_SHA,   1'b0, 8'h11},
        {OP_LOAD,  1'b1, 8'h00},
        {OP_SHB,   1'b1, 8'h00},
        {OP_INA,   1'b0, 8'hFF},
        {OP_LOAD,  1'b0, 8'hFF},
        {OP_SHA,   1'b0, 8'h00}
    };

    logic         sys_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_a_i = 1'b1;
    logic         clk_b_i = 1'b0;
    logic         load_n_i = 1'b1;
    logic         ser_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic         q_o, q_n_o, inh_viol_o;
    logic [W-1:0] stages_o;

    int           n_chk = 0;
    int           n_bad = 0;
    int           viol_cnt = 0;
    logic [W-1:0] model = '0;
    bit           done = 1'b0;

    always #2 sys_clk = ~sys_clk;

    gclk_piso #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .clk_a_i    (clk_a_i),
        .clk_b_i    (clk_b_i),
        .load_n_i   (load_n_i),
        .ser_i      (ser_i),
        .par_i      (par_i),
        .q_o        (q_o),
        .q_n_o      (q_n_o),
        .stages_o   (stages_o),
        .inh_viol_o (inh_viol_o)
    );

    // Count violation pulses, sampled away from the active edge.
    always @(negedge sys_clk) if (rst_n && inh_viol_o) viol_cnt++;

    task automatic settle();
        repeat (4) @(negedge sys_clk);
    endtask

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        check(tag, stages_o, model);
        check({tag, " R2 q_o"}, {7'd0, q_o}, {7'd0, model[W-1]});
        check("R8 complement", {7'd0, q_n_o}, {7'd0, ~q_o});
    endtask

    task automatic run_op(logic [2:0] op, logic s, logic [W-1:0] p);
        string tag;
        int    exp_viol;
        exp_viol = 0;
        viol_cnt = 0;
        ser_i = s;
        par_i = p;
        case (op)
            OP_LOAD: begin  // R2
                tag = "R2 load";
                load_n_i = 1'b0; settle();
                load_n_i = 1'b1; settle();
                model = p;
            end
            OP_SHA: begin  // R4
                tag = "R4 shift via A";
                clk_a_i = 1'b0; settle();
                clk_a_i = 1'b1; settle();
                model = {model[W-2:0], s};
            end
            OP_SHB: begin  // R6, and R9 violation expected
                tag = "R6 shift via B";
                clk_b_i = 1'b1; settle();
                clk_a_i = 1'b0; settle();
                clk_b_i = 1'b0; settle();
                clk_b_i = 1'b1; settle();
                clk_a_i = 1'b1; settle();
                clk_b_i = 1'b0; settle();
                model = {model[W-2:0], s};
                exp_viol = 1;
            end
            OP_INA: begin  // R5: B held high, A toggles
                tag = "R5 inhibit by B";
                clk_b_i = 1'b1; settle();
                clk_a_i = 1'b0; settle();
                clk_a_i = 1'b1; settle();
                clk_a_i = 1'b0; settle();
                clk_a_i = 1'b1; settle();
                clk_b_i = 1'b0; settle();
            end
            OP_INB: begin  // R5: A held high, B toggles
                tag = "R5 inhibit by A";
                clk_b_i = 1'b1; settle();
                clk_b_i = 1'b0; settle();
                clk_b_i = 1'b1; settle();
                clk_b_i = 1'b0; settle();
            end
            OP_LDCLK: begin  // R3
                tag = "R3 load over clocking";
                load_n_i = 1'b0; settle();
                clk_a_i = 1'b0; settle();
                clk_a_i = 1'b1; settle();
                clk_a_i = 1'b0; settle();
                clk_a_i = 1'b1; settle();
                load_n_i = 1'b1; settle();
                model = p;
            end
            default: begin  // R7
                tag = "R7 edge on load release";
                load_n_i = 1'b0;
                clk_a_i = 1'b0; settle();
                load_n_i = 1'b1;
                clk_a_i = 1'b1; settle();
                model = p;
            end
        endcase
        check_outs(tag);
        check("R9 violation pulses", W'(viol_cnt), W'(exp_viol));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge sys_clk);
        check("R1 reset stages", stages_o, '0);
        check("R1 reset q_o", {7'd0, q_o}, 8'd0);
        check("R1 reset q_n_o", {7'd0, q_n_o}, 8'd1);
        rst_n = 1'b1;
        settle();
        check("R1 after release", stages_o, '0);

        // Table walk
        for (int i = 0; i < NSTEP; i++) begin
            run_op(STEPS[i][11:9], STEPS[i][8], STEPS[i][7:0]);
        end

        // R10: full replacement by eight shifts of a constant
        run_op(OP_LOAD, 1'b0, 8'hA5);
        for (int k = 0; k < W - 1; k++) run_op(OP_SHA, 1'b0, 8'h00);
        check("R10 stage0 value at last stage", stages_o, 8'h80);
        run_op(OP_SHA, 1'b0, 8'h00);
        check("R10 full replace by zeros", stages_o, 8'h00);
        run_op(OP_LOAD, 1'b0, 8'h5A);
        for (int k = 0; k < W; k++) run_op(OP_SHA, 1'b1, 8'h00);
        check("R10 full replace by ones", stages_o, 8'hFF);

        // R9: inhibit raised while clock high gives no flag
        viol_cnt = 0;
        clk_b_i = 1'b1; settle();
        clk_b_i = 1'b0; settle();
        check("R9 legal inhibit raise", W'(viol_cnt), '0);

        // R1: mid-run reset clears a non-zero word
        run_op(OP_LOAD, 1'b0, 8'hC3);
        rst_n = 1'b0;
        repeat (2) @(negedge sys_clk);
        check("R1 mid-run reset", stages_o, '0);
        check("R1 mid-run q_n_o", {7'd0, q_n_o}, 8'd1);
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule